// File: doc/BRIEF.md
# Flash Block Lock-Bit Command Controller

This block holds the write-protection state of a block-erasable parallel flash. It watches bus write cycles, each carrying a command byte and an address, and keeps one protection bit per block. A protection bit is raised, or every protection bit is dropped, only through a two-cycle command pair. The second cycle of the pair must be the very next bus operation to the device. A read, or any other write, in that slot aborts the pair and raises two error flags.

Program and erase requests pass through the block. A request to an unprotected block is granted with a one-cycle pulse. A request to a protected block is refused and reported in the status byte. Error flags stay set until software clears them. While a protection change is under way, the ready flag drops for a fixed, parameterised number of cycles, and every write in that window is ignored.

A parameter chooses how reset treats the protection bits. In retained mode, reset does not clear them, which models storage that survives a power cycle. In volatile mode, reset marks every block as protected.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The write pair 0x60 then 0x01 sets the protection bit of the block whose index is the top log2(NUM_BLK) bits of `bus_addr` on the second write. No other protection bit changes.
- R2: The write pair 0x60 then 0xD0 clears the protection bit of every block at once.
- R3: After a 0x60 write, the pending pair is aborted, and status bits 5 and 4 are set with the protection bits unchanged, if the next bus operation is a read strobe or any write other than 0x01 or 0xD0. The aborting write is not executed. Cycles with neither strobe keep the pair pending.
- R4: A program request (write 0x40) or erase request (write 0x20) to an unprotected block pulses `prog_go_o` or `erase_go_o` for one cycle, starting on the cycle after the request. If the block is protected, no pulse is given. A refused program sets status bits 1 and 4, and a refused erase sets status bits 1 and 5.
- R5: Status bits 5, 4 and 1 remain set through later successful commands. Only a write of 0x50 clears them.
- R6: Status bit 7 reads 0 for exactly BUSY_CYC cycles, starting on the cycle after the second write of a successful pair. Any write during that window has no effect.
- R7: With PERSIST=1, asserting reset leaves every protection bit at its previous value.
- R8: With PERSIST=0, reset sets every protection bit.
- R9: After reset, the status byte reads 0x80, no pair is pending, and neither grant output is high.
- R10: Write commands other than 0x60, 0x50, 0x40 and 0x20, when no pair is pending, change neither the status byte nor the protection bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write cycle strobe, one bus write per high cycle |
| bus_re | input | 1 | Read cycle strobe (any non-write bus operation) |
| bus_cmd | input | 8 | Command byte of the write cycle |
| bus_addr | input | ADDR_W | Bus address; the top bits select the block |
| status_o | output | 8 | Status byte: bit 7 ready, 5 erase/clear error, 4 program/set error, 1 block protected |
| lock_o | output | NUM_BLK | Current protection bit of each block |
| prog_go_o | output | 1 | One-cycle grant of a program request |
| erase_go_o | output | 1 | One-cycle grant of an erase request |

## Verification
Every result of a bus operation is registered once. The protection bits, the error flags, the falling ready flag and the grant pulses all become visible on the clock edge that ends the cycle carrying the operation. Ready returns BUSY_CYC edges after it drops. The bench drives each operation for one full cycle from the falling edge. It compares the outputs of both reset variants with a behavioural model at every falling edge, which is half a cycle after the edge that updated them. The directed checks count the idle cycles of the busy window one at a time, so that the last low cycle and the first high cycle are each sampled.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

   // command bytes
   localparam logic [7:0] CMD_PAIR_OPEN  = 8'h60;
   localparam logic [7:0] CMD_PAIR_SET   = 8'h01;
   localparam logic [7:0] CMD_PAIR_CLEAR = 8'hD0;
   localparam logic [7:0] CMD_FLAG_CLEAR = 8'h50;
   localparam logic [7:0] CMD_PROGRAM    = 8'h40;
   localparam logic [7:0] CMD_ERASE      = 8'h20;

   // status bit positions
   localparam int ST_READY     = 7;
   localparam int ST_ERASE_ERR = 5;
   localparam int ST_PROG_ERR  = 4;
   localparam int ST_PROTECTED = 1;

   // one-cycle events decoded from the bus
   typedef struct packed {
      logic set_one;
      logic clr_all;
      logic seq_err;
      logic prog_ref;
      logic erase_ref;
      logic flag_clr;
      logic prog_ok;
      logic erase_ok;
   } flc_evt_t;

endpackage

// File: rtl/flc_cmd_decode.sv
module flc_cmd_decode
   import flash_lock_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BLK_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [7:0]        bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              busy,
   input  logic              blk_locked,
   output logic [BLK_W-1:0]  blk_idx,
   output logic              pend_o,
   output flc_evt_t          evt
);

   logic pend_q;

   assign blk_idx = bus_addr[ADDR_W-1 -: BLK_W];
   assign pend_o  = pend_q;

   always_comb begin
      evt = '0;
      if (!busy) begin
         if (pend_q) begin
            if (bus_we && bus_cmd == CMD_PAIR_SET)        evt.set_one = 1'b1;
            else if (bus_we && bus_cmd == CMD_PAIR_CLEAR) evt.clr_all = 1'b1;
            else if (bus_we || bus_re)                    evt.seq_err = 1'b1;
         end else if (bus_we) begin
            unique case (bus_cmd)
               CMD_FLAG_CLEAR: evt.flag_clr = 1'b1;
               CMD_PROGRAM: begin
                  evt.prog_ref = blk_locked;
                  evt.prog_ok  = !blk_locked;
               end
               CMD_ERASE: begin
                  evt.erase_ref = blk_locked;
                  evt.erase_ok  = !blk_locked;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!busy) begin
         if (pend_q) begin
            if (bus_we || bus_re) pend_q <= 1'b0;
         end else if (bus_we && bus_cmd == CMD_PAIR_OPEN) begin
            pend_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/flc_lock_bank.sv
module flc_lock_bank #(
   parameter int NUM_BLK = 8,
   parameter int BLK_W   = 3,
   parameter bit PERSIST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_one,
   input  logic               clr_all,
   input  logic [BLK_W-1:0]   blk_idx,
   output logic [NUM_BLK-1:0] lock_o
);

   logic [NUM_BLK-1:0] lock_q;
   logic [NUM_BLK-1:0] lock_d;

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_next
      assign lock_d[i] = clr_all ? 1'b0 :
                         (set_one && blk_idx == BLK_W'(i)) ? 1'b1 : lock_q[i];
   end

   if (PERSIST) begin : g_retained
      // reset does not touch the bits; it only blocks updates while held
      always_ff @(posedge clk) begin
         if (rst_n) lock_q <= lock_d;
      end
   end else begin : g_volatile
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lock_q <= '1;
         else        lock_q <= lock_d;
      end
   end

   assign lock_o = lock_q;

endmodule

// File: rtl/flc_status.sv
module flc_status
   import flash_lock_pkg::*;
#(
   parameter int BUSY_CYC = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  flc_evt_t evt,
   output logic     busy_o,
   output logic     prog_go_o,
   output logic     erase_go_o,
   output logic [7:0] status_o
);

   localparam int CNT_W = $clog2(BUSY_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic erase_err_q, prog_err_q, prot_q;
   logic pgo_q, ego_q;

   assign busy_o = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         erase_err_q <= 1'b0;
         prog_err_q  <= 1'b0;
         prot_q      <= 1'b0;
         pgo_q       <= 1'b0;
         ego_q       <= 1'b0;
      end else begin
         pgo_q <= evt.prog_ok;
         ego_q <= evt.erase_ok;
         if (evt.set_one || evt.clr_all) cnt_q <= CNT_W'(BUSY_CYC);
         else if (busy_o)                cnt_q <= cnt_q - 1'b1;
         if (evt.flag_clr) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
            prot_q      <= 1'b0;
         end else begin
            if (evt.seq_err || evt.erase_ref) erase_err_q <= 1'b1;
            if (evt.seq_err || evt.prog_ref)  prog_err_q  <= 1'b1;
            if (evt.prog_ref || evt.erase_ref) prot_q     <= 1'b1;
         end
      end
   end

   assign prog_go_o  = pgo_q;
   assign erase_go_o = ego_q;

   always_comb begin
      status_o               = '0;
      status_o[ST_READY]     = !busy_o;
      status_o[ST_ERASE_ERR] = erase_err_q;
      status_o[ST_PROG_ERR]  = prog_err_q;
      status_o[ST_PROTECTED] = prot_q;
   end

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
   import flash_lock_pkg::*;
#(
   parameter int NUM_BLK  = 8,
   parameter int ADDR_W   = 16,
   parameter int BUSY_CYC = 4,
   parameter bit PERSIST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic               bus_re,
   input  logic [7:0]         bus_cmd,
   input  logic [ADDR_W-1:0]  bus_addr,
   output logic [7:0]         status_o,
   output logic [NUM_BLK-1:0] lock_o,
   output logic               prog_go_o,
   output logic               erase_go_o
);

   localparam int BLK_W = $clog2(NUM_BLK);

   if (NUM_BLK < 2 || (NUM_BLK & (NUM_BLK - 1)) != 0) begin : g_bad_blocks
      $error("NUM_BLK must be a power of two of at least 2");
   end
   if (ADDR_W < BLK_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the block index");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end

   flc_evt_t           evt;
   logic [BLK_W-1:0]   blk_idx;
   logic               busy;
   logic               seq_pend;

   flc_cmd_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_re     (bus_re),
      .bus_cmd    (bus_cmd),
      .bus_addr   (bus_addr),
      .busy       (busy),
      .blk_locked (lock_o[blk_idx]),
      .blk_idx    (blk_idx),
      .pend_o     (seq_pend),
      .evt        (evt)
   );

   flc_lock_bank #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .PERSIST(PERSIST)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_one (evt.set_one),
      .clr_all (evt.clr_all),
      .blk_idx (blk_idx),
      .lock_o  (lock_o)
   );

   flc_status #(.BUSY_CYC(BUSY_CYC)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .busy_o     (busy),
      .prog_go_o  (prog_go_o),
      .erase_go_o (erase_go_o),
      .status_o   (status_o)
   );

endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk
   import flash_lock_pkg::*;
#(
   parameter int NUM_BLK = 8,
   parameter int ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_we,
   input logic               bus_re,
   input logic [7:0]         bus_cmd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [7:0]         status_o,
   input logic [NUM_BLK-1:0] lock_o,
   input logic               prog_go_o,
   input logic               erase_go_o,
   input logic               seq_pend
);

   localparam int BW = $clog2(NUM_BLK);
   logic [BW-1:0] chk_blk;
   assign chk_blk = bus_addr[ADDR_W-1 -: BW];

   // R2: a completed clear pair leaves no block protected
   p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_pend && status_o[ST_READY] && bus_we && bus_cmd == CMD_PAIR_CLEAR)
      |=> (lock_o == '0));

   // R3: an interrupted pair raises both error flags and changes no protection
   p_abort_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_pend && status_o[ST_READY] &&
       (bus_re || (bus_we && bus_cmd != CMD_PAIR_SET && bus_cmd != CMD_PAIR_CLEAR)))
      |=> (status_o[ST_ERASE_ERR] && status_o[ST_PROG_ERR] && $stable(lock_o)));

   // R4: program to a protected block is refused and flagged
   p_refuse_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_pend && status_o[ST_READY] && bus_we && bus_cmd == CMD_PROGRAM && lock_o[chk_blk])
      |=> (!prog_go_o && status_o[ST_PROTECTED] && status_o[ST_PROG_ERR]));

   // R4: at most one grant at a time
   p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_go_o, erase_go_o}));

   // R5: the protected flag holds unless a flag-clear write arrives
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[ST_PROTECTED] && !(bus_we && bus_cmd == CMD_FLAG_CLEAR))
      |=> status_o[ST_PROTECTED]);

   // R6: protection bits stay put during the busy window
   p_busy_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[ST_READY] |=> $stable(lock_o));

endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_re     (bus_re),
   .bus_cmd    (bus_cmd),
   .bus_addr   (bus_addr),
   .status_o   (status_o),
   .lock_o     (lock_o),
   .prog_go_o  (prog_go_o),
   .erase_go_o (erase_go_o),
   .seq_pend   (seq_pend)
);

// File: tb/flash_lock_ctrl_test.sv
`timescale 1ns/1ps
module flash_lock_ctrl_test;

   localparam int NB = 8;
   localparam int AW = 16;
   localparam int BC = 4;
   localparam int BW = $clog2(NB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0] bus_cmd = 8'h00;
   logic [AW-1:0] bus_addr = '0;

   logic [7:0]    st_p, st_v;
   logic [NB-1:0] lk_p, lk_v;
   logic pg_p, eg_p, pg_v, eg_v;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   flash_lock_ctrl #(.NUM_BLK(NB), .ADDR_W(AW), .BUSY_CYC(BC), .PERSIST(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .status_o(st_p), .lock_o(lk_p), .prog_go_o(pg_p), .erase_go_o(eg_p));

   flash_lock_ctrl #(.NUM_BLK(NB), .ADDR_W(AW), .BUSY_CYC(BC), .PERSIST(1'b0)) uut_vol (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .status_o(st_v), .lock_o(lk_v), .prog_go_o(pg_v), .erase_go_o(eg_v));

   // ---------------- behavioural reference, index 0 retained, 1 volatile
   int m_cnt [2];
   bit m_pend[2], m_e5[2], m_e4[2], m_e1[2], m_pg[2], m_eg[2], m_known[2];
   bit m_lock[2][NB];

   always @(posedge clk or negedge rst_n) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            m_cnt[k] = 0; m_pend[k] = 0; m_e5[k] = 0; m_e4[k] = 0; m_e1[k] = 0;
            m_pg[k] = 0; m_eg[k] = 0;
            if (k == 1) begin
               for (int b = 0; b < NB; b++) m_lock[k][b] = 1;
               m_known[k] = 1;
            end
         end else begin
            int blk;
            bit was_busy;
            blk = int'(bus_addr) >> (AW - BW);
            was_busy = (m_cnt[k] != 0);
            m_pg[k] = 0; m_eg[k] = 0;
            if (was_busy) m_cnt[k]--;
            else if (m_pend[k]) begin
               if (bus_we && bus_cmd == 8'h01) begin
                  m_lock[k][blk] = 1; m_cnt[k] = BC; m_pend[k] = 0;
               end else if (bus_we && bus_cmd == 8'hD0) begin
                  for (int b = 0; b < NB; b++) m_lock[k][b] = 0;
                  m_known[k] = 1; m_cnt[k] = BC; m_pend[k] = 0;
               end else if (bus_we || bus_re) begin
                  m_e5[k] = 1; m_e4[k] = 1; m_pend[k] = 0;
               end
            end else if (bus_we) begin
               if (bus_cmd == 8'h60) m_pend[k] = 1;
               else if (bus_cmd == 8'h50) begin m_e5[k] = 0; m_e4[k] = 0; m_e1[k] = 0; end
               else if (bus_cmd == 8'h40) begin
                  if (m_lock[k][blk]) begin m_e1[k] = 1; m_e4[k] = 1; end else m_pg[k] = 1;
               end else if (bus_cmd == 8'h20) begin
                  if (m_lock[k][blk]) begin m_e1[k] = 1; m_e5[k] = 1; end else m_eg[k] = 1;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison half a cycle after the updating edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < 2; k++) begin
            logic [7:0] es, as;
            logic [NB-1:0] el, al;
            es = {m_cnt[k] == 0, 1'b0, m_e5[k], m_e4[k], 2'b00, m_e1[k], 1'b0};
            for (int b = 0; b < NB; b++) el[b] = m_lock[k][b];
            as = (k == 0) ? st_p : st_v;
            al = (k == 0) ? lk_p : lk_v;
            chk(as == es, "model status R3 R4 R5 R6 R10", as, es);
            chk(((k == 0) ? pg_p : pg_v) == m_pg[k], "model program grant R4",
                (k == 0) ? pg_p : pg_v, m_pg[k]);
            chk(((k == 0) ? eg_p : eg_v) == m_eg[k], "model erase grant R4",
                (k == 0) ? eg_p : eg_v, m_eg[k]);
            if (m_known[k]) chk(al == el, "model protection R1 R2 R7 R8", al, el);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers, each drives one cycle from a falling edge
   function automatic logic [AW-1:0] ba(input int b);
      return AW'(b) << (AW - BW);
   endfunction

   task automatic wr(input logic [7:0] c, input int b);
      bus_we = 1; bus_re = 0; bus_cmd = c; bus_addr = ba(b);
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd();
      bus_re = 1; bus_we = 0;
      @(negedge clk);
      bus_re = 0;
   endtask

   task automatic idle(input int n);
      bus_we = 0; bus_re = 0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      chk(st_p == 8'h80 && st_v == 8'h80, "R9 status after reset", st_p, 8'h80);
      chk(!pg_p && !eg_p && !pg_v && !eg_v, "R9 grants idle", pg_p, 0);
      // R8 volatile reset protects all
      chk(lk_v == '1, "R8 all protected after reset", lk_v, 8'hFF);

      // R2 clear all, then R6 busy window length
      wr(8'h60, 0); wr(8'hD0, 0);
      chk(lk_p == '0 && lk_v == '0, "R2 clear all", lk_p, 0);
      chk(st_p[7] == 1'b0, "R6 ready drops", st_p, 8'h00);
      idle(BC - 1);
      chk(st_p[7] == 1'b0, "R6 last busy cycle", st_p, 8'h00);
      idle(1);
      chk(st_p == 8'h80, "R6 ready returns", st_p, 8'h80);

      // R1 set block 3; R6 writes during busy ignored
      wr(8'h60, 0); wr(8'h01, 3);
      chk(lk_p == 8'b0000_1000, "R1 set one block", lk_p, 8'h08);
      wr(8'h60, 0); wr(8'h01, 5);
      idle(BC);
      chk(lk_p == 8'b0000_1000, "R6 busy writes ignored", lk_p, 8'h08);
      wr(8'h40, 0);
      chk(pg_p == 1'b1 && st_p == 8'h80, "R6 no pair left pending", st_p, 8'h80);

      // R4 refusals and grants
      wr(8'h40, 3);
      chk(!pg_p && st_p == 8'h92, "R4 program refused", st_p, 8'h92);
      wr(8'h20, 3);
      chk(!eg_p && st_p == 8'hB2, "R4 erase refused", st_p, 8'hB2);
      wr(8'h20, 1);
      chk(eg_p == 1'b1, "R4 erase granted", eg_p, 1);
      // R5 sticky through success, cleared by 0x50
      chk(st_p == 8'hB2, "R5 flags sticky", st_p, 8'hB2);
      idle(1);
      chk(eg_p == 1'b0, "R4 grant lasts one cycle", eg_p, 0);
      wr(8'h50, 0);
      chk(st_p == 8'h80, "R5 flag clear", st_p, 8'h80);

      // R10 unknown command ignored
      wr(8'hFF, 2); wr(8'h90, 4);
      chk(st_p == 8'h80 && lk_p == 8'h08, "R10 unknown command", st_p, 8'h80);

      // R3 interruptions
      wr(8'h60, 0); idle(2); rd();
      chk(st_p == 8'hB0 && lk_p == 8'h08, "R3 read aborts pair", st_p, 8'hB0);
      wr(8'h50, 0);
      wr(8'h60, 0); wr(8'h40, 0);
      chk(st_p == 8'hB0 && !pg_p, "R3 write aborts, not executed", st_p, 8'hB0);
      wr(8'h50, 0);
      wr(8'h60, 0); idle(1); wr(8'h01, 6);
      chk(lk_p == 8'b0100_1000, "R3 idle keeps pair pending", lk_p, 8'h48);
      idle(BC);

      // R7 / R8 reset mid run
      rst_n = 0;
      idle(2);
      chk(lk_p == 8'b0100_1000, "R7 retained through reset", lk_p, 8'h48);
      chk(lk_v == '1, "R8 volatile protected on reset", lk_v, 8'hFF);
      rst_n = 1;
      idle(1);
      chk(st_p == 8'h80 && st_v == 8'h80, "R9 status after second reset", st_p, 8'h80);
      wr(8'h20, 2);
      chk(!eg_v && eg_p, "R8 volatile refuses until cleared", eg_v, 0);
      wr(8'h50, 0);
      wr(8'h60, 0); wr(8'hD0, 0); idle(BC);
      wr(8'h20, 6);
      chk(eg_v == 1'b1 && eg_p == 1'b1, "R2 erase after clear", eg_v, 1);
      idle(2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule